// File: doc/BRIEF.md
# Card Power and Clock Sequencer

This block sits between a memory-card host's kernel clock and its card pads. It holds the card interface power mode, derives the card clock from the kernel clock through a programmable divider, and tells the pad ring how to drive the card lines. In power-cycle mode the lines are pulled low, so the card cannot draw supply through its signal pins. In power-off mode they are held high. In power-on mode they are driven normally.

After entering power-on, the interface reports itself enabled only after a fixed count of card-clock cycles has elapsed. The divider divides the kernel clock by twice its value. A divider of zero is a bypass in which the kernel clock itself is the card clock. A power-save option stops the card clock while the bus is idle. Divider changes are applied only at the boundary where a high phase ends, so the card clock never produces a runt pulse.

Top module: `cardclk_seq`

## Requirements
- R1: After synchronous reset the power mode is off, `line_drv` is 2'b10 (drive high), `card_clk` and `if_enabled` are 0, and `bus_lanes` is 2'b00.
- R2: A power write loads `pwr_val` when it is 2'b00 (off), 2'b10 (cycle) or 2'b11 (on). A write of 2'b01 is ignored and the previous mode is kept.
- R3: In cycle mode `line_drv` is 2'b01 (drive low), `card_clk` is 0, `card_clk_en` is 0 and `if_enabled` is 0.
- R4: `line_drv` is 2'b10 in off mode and 2'b00 (normal) in on mode. `if_enabled` is 0 whenever the mode is not on.
- R5: After entering on mode, `if_enabled` stays 0 until `LOCK_CYCLES` (default 74) card-clock ticks have been signalled on `card_clk_en`. It rises in the cycle after the last of those ticks.
- R6: Leaving on mode and re-entering it restarts the lockout count from zero.
- R7: With a divider value N > 0 and the clock running, `card_clk` is high for N kernel cycles and low for N kernel cycles. A pulse on `card_clk_en` precedes each rising edge by one kernel cycle.
- R8: With divider 0 in on mode and the clock running, `card_clk` follows the kernel clock, `card_clk_en` is 1 in every cycle, and `launch_fall` is 1.
- R9: With a nonzero divider, `launch_fall` equals the edge-select bit `cfg_fall_edge`.
- R10: `bus_lanes` is 2'b00 for 1-bit mode, 2'b01 when only `cfg_wide4` is set, and 2'b10 when `cfg_wide8` is set; `cfg_wide8` wins if both are set.
- R11: With `cfg_psave` set and `bus_idle` high, the card clock stops in its low state and `card_clk_en` stays 0. Dropping `bus_idle` restarts it.
- R12: A divider written during a high phase does not shorten that phase. The new value takes effect from the following low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_wr | input | 1 | Power mode write strobe |
| pwr_val | input | 2 | Power mode value |
| cfg_wr | input | 1 | Clock configuration write strobe |
| cfg_div | input | DIV_W | Divider value (0 = bypass) |
| cfg_fall_edge | input | 1 | Launch on falling card-clock edge when divider is nonzero |
| cfg_psave | input | 1 | Stop card clock while bus idle |
| cfg_wide4 | input | 1 | Select 4-bit bus |
| cfg_wide8 | input | 1 | Select 8-bit bus |
| bus_idle | input | 1 | Bus has no command or data activity |
| card_clk | output | 1 | Card clock |
| card_clk_en | output | 1 | A card-clock rising edge occurs at the next kernel edge |
| line_drv | output | 2 | Line drive: 00 normal, 01 low, 10 high |
| if_enabled | output | 1 | Interface enabled after lockout |
| launch_fall | output | 1 | Command/data launched on falling card-clock edge |
| bus_lanes | output | 2 | Bus width code |

## Verification
Divider values 1, 2, 3, 5, 7 and 12 are swept with both edge selections and all four bus-width bit combinations. The measured high and low widths separate an off-by-one in the divider compare from a wrong reload, and the width combinations expose a priority slip. Bypass is tried separately, because there the edge flag and the per-cycle tick behave differently from every divided setting. The lockout is counted in ticks, first in bypass and again at divider 2 after a cycle-then-on sequence, which tells a count tied to kernel cycles apart from one tied to card cycles, and shows whether the count restarts on re-entry. A mid-high-phase divider change and power-save with the bus idle and then busy check the glitch-free reload and the low-state stop.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

    typedef enum logic [1:0] {
        PM_OFF   = 2'b00,
        PM_CYCLE = 2'b10,
        PM_ON    = 2'b11
    } pwr_mode_e;

    typedef enum logic [1:0] {
        LD_NORMAL = 2'b00,
        LD_LOW    = 2'b01,
        LD_HIGH   = 2'b10
    } line_drv_e;

    typedef struct packed {
        logic fall_edge;
        logic psave;
        logic wide4;
        logic wide8;
    } clk_flags_t;

    function automatic logic [1:0] lanes_code(input logic w4, input logic w8);
        if (w8)      return 2'b10;
        else if (w4) return 2'b01;
        else         return 2'b00;
    endfunction

    function automatic line_drv_e line_for(input pwr_mode_e m);
        case (m)
            PM_CYCLE: return LD_LOW;
            PM_ON:    return LD_NORMAL;
            default:  return LD_HIGH;
        endcase
    endfunction

endpackage

// File: rtl/cardclk_pwr_ctl.sv
module cardclk_pwr_ctl
    import cardclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  logic [1:0] val,
    output pwr_mode_e mode,
    output line_drv_e line
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= PM_OFF;
        end else if (wr && (val != 2'b01)) begin
            mode <= pwr_mode_e'(val);
        end
    end

    assign line = line_for(mode);
endmodule

// File: rtl/cardclk_divider.sv
module cardclk_divider #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_new,
    output logic             tick,
    output logic             phase,
    output logic [DIV_W-1:0] act_div
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;
    logic             bypass;
    logic             load;

    assign bypass = (act_div == '0);
    assign wrap   = (cnt == act_div - 1'b1);
    // reload only where no phase is cut short: end of high, or parked low
    assign load   = bypass || (phase && wrap) || (!phase && !run);
    assign tick   = run && (bypass || (!phase && wrap));

    always_ff @(posedge clk) begin
        if (rst) begin
            act_div <= '0;
            cnt     <= '0;
            phase   <= 1'b0;
        end else begin
            if (load) act_div <= div_new;
            if (bypass) begin
                cnt   <= '0;
                phase <= 1'b0;
            end else if (phase) begin
                if (wrap) begin
                    cnt   <= '0;
                    phase <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (!run) begin
                cnt <= '0;
            end else if (wrap) begin
                cnt   <= '0;
                phase <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cardclk_lockout.sv
module cardclk_lockout #(
    parameter int LOCK_CYCLES = 74
) (
    input  logic clk,
    input  logic rst,
    input  logic on,
    input  logic tick,
    output logic enabled
);
    localparam int LK_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [LK_W-1:0] LK_LAST = LK_W'(LOCK_CYCLES - 1);

    logic [LK_W-1:0] lk;
    logic            en_q;

    always_ff @(posedge clk) begin
        if (rst || !on) begin
            lk   <= '0;
            en_q <= 1'b0;
        end else if (!en_q && tick) begin
            if (lk == LK_LAST) en_q <= 1'b1;
            else               lk   <= lk + 1'b1;
        end
    end

    assign enabled = en_q && on;
endmodule

// File: rtl/cardclk_seq.sv
module cardclk_seq
    import cardclk_pkg::*;
#(
    parameter int DIV_W       = 10,
    parameter int LOCK_CYCLES = 74
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_wr,
    input  logic [1:0]       pwr_val,
    input  logic             cfg_wr,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_fall_edge,
    input  logic             cfg_psave,
    input  logic             cfg_wide4,
    input  logic             cfg_wide8,
    input  logic             bus_idle,
    output logic             card_clk,
    output logic             card_clk_en,
    output logic [1:0]       line_drv,
    output logic             if_enabled,
    output logic             launch_fall,
    output logic [1:0]       bus_lanes
);
    pwr_mode_e        mode;
    line_drv_e        line;
    clk_flags_t       flags_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] act_div;
    logic             phase;
    logic             tick;
    logic             is_on;
    logic             run;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            div_q   <= '0;
        end else if (cfg_wr) begin
            div_q   <= cfg_div;
            flags_q <= '{fall_edge: cfg_fall_edge, psave: cfg_psave,
                         wide4: cfg_wide4, wide8: cfg_wide8};
        end
    end

    assign is_on = (mode == PM_ON);
    assign run   = is_on && !(flags_q.psave && bus_idle);

    cardclk_pwr_ctl u_pwr (
        .clk  (clk),
        .rst  (rst),
        .wr   (pwr_wr),
        .val  (pwr_val),
        .mode (mode),
        .line (line)
    );

    cardclk_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .div_new (div_q),
        .tick    (tick),
        .phase   (phase),
        .act_div (act_div)
    );

    cardclk_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk     (clk),
        .rst     (rst),
        .on      (is_on),
        .tick    (tick),
        .enabled (if_enabled)
    );

    always_comb begin
        if (!is_on)               card_clk = 1'b0;
        else if (act_div == '0)   card_clk = run ? clk : 1'b0;
        else                      card_clk = phase;
    end

    assign card_clk_en = tick;
    assign line_drv    = line;
    assign launch_fall = (act_div == '0) || flags_q.fall_edge;
    assign bus_lanes   = lanes_code(flags_q.wide4, flags_q.wide8);
endmodule

// File: rtl/cardclk_seq_chk.sv
module cardclk_seq_chk #(
    parameter int DIV_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             card_clk,
    input logic             card_clk_en,
    input logic [1:0]       line_drv,
    input logic             if_enabled,
    input logic [1:0]       bus_lanes,
    input logic [DIV_W-1:0] act_div,
    input logic             psave,
    input logic             bus_idle
);
    p_lines_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (line_drv != 2'b00) |-> (!card_clk_en && !if_enabled && !card_clk));

    p_enable_after_tick_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(if_enabled) |-> $past(card_clk_en));

    p_tick_then_rise_r7: assert property (@(posedge clk) disable iff (rst)
        (card_clk_en && act_div != '0) |=> (card_clk || line_drv != 2'b00));

    p_bypass_tick_r8: assert property (@(posedge clk) disable iff (rst)
        (act_div == '0 && line_drv == 2'b00 && !(psave && bus_idle)) |-> card_clk_en);

    p_lanes_legal_r10: assert property (@(posedge clk) disable iff (rst)
        bus_lanes != 2'b11);

    p_psave_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (act_div != '0 && psave && bus_idle && !card_clk) |-> !card_clk_en);
endmodule

bind cardclk_seq cardclk_seq_chk #(.DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .card_clk    (card_clk),
    .card_clk_en (card_clk_en),
    .line_drv    (line_drv),
    .if_enabled  (if_enabled),
    .bus_lanes   (bus_lanes),
    .act_div     (act_div),
    .psave       (flags_q.psave),
    .bus_idle    (bus_idle)
);

// File: tb/cardclk_seq_test.sv
`timescale 1ns/1ps
module cardclk_seq_test;
    localparam int DIV_W = 10;
    localparam int LOCK  = 74;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pwr_wr = 1'b0;
    logic [1:0]       pwr_val = 2'b00;
    logic             cfg_wr = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic             cfg_fall_edge = 1'b0;
    logic             cfg_psave = 1'b0;
    logic             cfg_wide4 = 1'b0;
    logic             cfg_wide8 = 1'b0;
    logic             bus_idle = 1'b0;
    logic             card_clk;
    logic             card_clk_en;
    logic [1:0]       line_drv;
    logic             if_enabled;
    logic             launch_fall;
    logic [1:0]       bus_lanes;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    cardclk_seq #(.DIV_W(DIV_W), .LOCK_CYCLES(LOCK)) uut (
        .clk(clk), .rst(rst), .pwr_wr(pwr_wr), .pwr_val(pwr_val),
        .cfg_wr(cfg_wr), .cfg_div(cfg_div), .cfg_fall_edge(cfg_fall_edge),
        .cfg_psave(cfg_psave), .cfg_wide4(cfg_wide4), .cfg_wide8(cfg_wide8),
        .bus_idle(bus_idle), .card_clk(card_clk), .card_clk_en(card_clk_en),
        .line_drv(line_drv), .if_enabled(if_enabled),
        .launch_fall(launch_fall), .bus_lanes(bus_lanes)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_pwr(input logic [1:0] v);
        @(negedge clk);
        pwr_wr = 1'b1; pwr_val = v;
        @(negedge clk);
        pwr_wr = 1'b0;
    endtask

    task automatic wr_cfg(input int d, input logic fe, input logic ps,
                          input logic w4, input logic w8);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_div = DIV_W'(d); cfg_fall_edge = fe;
        cfg_psave = ps; cfg_wide4 = w4; cfg_wide8 = w8;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // pwr write must be applied at the posedge right before the first sample
    task automatic lockout_count(input string tag);
        int ticks = 0;
        int guard = 0;
        pwr_wr = 1'b1; pwr_val = 2'b11;
        @(negedge clk);
        pwr_wr = 1'b0;
        while (!if_enabled && guard < 20000) begin
            if (card_clk_en) ticks++;
            guard++;
            @(negedge clk);
        end
        chk(tag, ticks, LOCK);
    endtask

    task automatic measure(input int n, input string tag);
        int hi = 0;
        int lo = 0;
        int guard = 0;
        while (!(card_clk == 1'b0) && guard < 100) begin @(negedge clk); guard++; end
        while (!(card_clk == 1'b1) && guard < 100) begin @(negedge clk); guard++; end
        while (card_clk == 1'b1 && guard < 200) begin hi++; @(negedge clk); guard++; end
        while (card_clk == 1'b0 && guard < 300) begin lo++; @(negedge clk); guard++; end
        chk({tag, " high"}, hi, n);
        chk({tag, " low"}, lo, n);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int sweep [6] = '{1, 2, 3, 5, 7, 12};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 line_drv", line_drv, 2'b10);
        chk("R1 card_clk", card_clk, 0);
        chk("R1 if_enabled", if_enabled, 0);
        chk("R1 bus_lanes", bus_lanes, 0);

        // R2 illegal code ignored
        wr_pwr(2'b01);
        chk("R2 01 ignored", line_drv, 2'b10);
        // R3 power-cycle drives low
        wr_pwr(2'b10);
        chk("R3 line low", line_drv, 2'b01);
        chk("R3 clk low", card_clk, 0);
        chk("R3 no tick", card_clk_en, 0);
        wr_pwr(2'b01);
        chk("R2 01 ignored in cycle", line_drv, 2'b01);

        // R5 lockout in bypass
        cfg_div = '0;
        lockout_count("R5 ticks before enable (bypass)");
        chk("R4 line normal when on", line_drv, 2'b00);
        // R8 bypass behaviour
        chk("R8 tick every cycle", card_clk_en, 1);
        chk("R8 launch_fall", launch_fall, 1);
        chk("R8 card_clk low at kernel low", card_clk, 0);
        @(posedge clk); #1;
        chk("R8 card_clk high at kernel high", card_clk, 1);

        // R6 restart via cycle, at divider 2
        wr_cfg(2, 1'b0, 1'b0, 1'b0, 1'b0);
        wr_pwr(2'b10);
        chk("R4 enabled drops off on", if_enabled, 0);
        repeat (4) @(negedge clk);
        lockout_count("R6 lockout restarts (div 2)");

        // R7 R9 R10 sweep
        foreach (sweep[i]) begin
            for (int m = 0; m < 4; m++) begin
                wr_cfg(sweep[i], m[0], 1'b0, m[0], m[1]);
                repeat (4 * sweep[i] + 2) @(negedge clk);
                measure(sweep[i], $sformatf("R7 div %0d", sweep[i]));
                chk($sformatf("R9 div %0d edge", sweep[i]), launch_fall, m[0]);
                chk($sformatf("R10 lanes w4=%0d w8=%0d", m[0], m[1]), bus_lanes,
                    m[1] ? 2 : (m[0] ? 1 : 0));
            end
        end

        // R12 divider change during high phase
        wr_cfg(6, 1'b0, 1'b0, 1'b0, 1'b0);
        repeat (30) @(negedge clk);
        begin
            int hi = 0;
            int lo = 0;
            int hi2 = 0;
            int guard = 0;
            while (!(card_clk == 1'b0) && guard < 100) begin @(negedge clk); guard++; end
            while (!(card_clk == 1'b1) && guard < 100) begin @(negedge clk); guard++; end
            cfg_wr = 1'b1; cfg_div = DIV_W'(2);
            hi = 1;
            @(negedge clk);
            cfg_wr = 1'b0;
            while (card_clk == 1'b1 && guard < 200) begin hi++; @(negedge clk); guard++; end
            while (card_clk == 1'b0 && guard < 300) begin lo++; @(negedge clk); guard++; end
            while (card_clk == 1'b1 && guard < 400) begin hi2++; @(negedge clk); guard++; end
            chk("R12 current high kept", hi, 6);
            chk("R12 next low new", lo, 2);
            chk("R12 next high new", hi2, 2);
        end

        // R11 power save
        wr_cfg(3, 1'b0, 1'b1, 1'b0, 1'b0);
        bus_idle = 1'b1;
        repeat (10) @(negedge clk);
        begin
            int seen_tick = 0;
            int seen_high = 0;
            for (int k = 0; k < 24; k++) begin
                if (card_clk_en) seen_tick++;
                if (card_clk) seen_high++;
                @(negedge clk);
            end
            chk("R11 no tick while idle", seen_tick, 0);
            chk("R11 clk held low", seen_high, 0);
            bus_idle = 1'b0;
            seen_tick = 0;
            for (int k = 0; k < 10; k++) begin
                if (card_clk_en) seen_tick++;
                @(negedge clk);
            end
            chk("R11 restarts when busy", seen_tick > 0, 1);
        end
        wr_cfg(0, 1'b0, 1'b1, 1'b0, 1'b0);
        bus_idle = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 bypass stopped tick", card_clk_en, 0);
        chk("R11 bypass stopped clk", card_clk, 0);
        bus_idle = 1'b0;

        // R4 power-off
        wr_pwr(2'b00);
        chk("R4 line high when off", line_drv, 2'b10);
        chk("R4 disabled when off", if_enabled, 0);
        chk("R2 off loaded, no tick", card_clk_en, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule